// File: doc/BRIEF.md
# Comparator Change-Detect Interrupt Logic

This block watches the asynchronous outputs of analog comparators and raises a per-channel interrupt flag when a comparator level no longer matches the level that software saw at its last access to the control register. Each comparator bit passes through a synchronizer. A sample latch then takes the synchronized level once per instruction cycle, on a strobe. A snapshot latch takes the sample latch value on every control-register access, whether read or write. The XOR of the two latches is the mismatch.

The flag is held at 1 for as long as the mismatch lasts. A software clear therefore takes effect only after a control-register access, or after the comparator has returned to the snapshot level. Software can write 1 to a flag bit to raise an interrupt by hand. The interrupt request goes out only when the flag, its channel enable, the peripheral enable and the global enable are all 1. All channels share the one control register, but each has its own flag and channel enable.

Top module: `cmp_chg_irq`

## Requirements
- R1: While rst_n is low and after its release, every flag, sample latch and snapshot latch is 0 and irq is 0. A control-register read then returns 0, and a flag-register read returns 0.
- R2: A read at address 0 (control) returns the sample-latch levels in bits [NCH-1:0], with the remaining bits 0.
- R3: When a channel's sample latch differs from its snapshot latch, that channel's flag becomes 1 on the next clock. Other channels are not affected.
- R4: The sample latch loads the synchronized comparator level only in cycles with cyc_stb high. A comparator change with cyc_stb held low neither sets a flag nor shows in control reads.
- R5: A read at address 0 loads each snapshot latch from its sample latch. This ends the mismatch, and a later write of 0 to address 1 (flags) then clears the flag.
- R6: A write at address 0 ends the mismatch in the same way as a read does.
- R7: If the comparator returns to the snapshot level, the mismatch ends without any register access, and a flag clear then succeeds.
- R8: A write of 0 to a flag bit has no effect while that channel's mismatch is active, including when the write lands in the same cycle as a new mismatch.
- R9: Writing 1 to a flag bit at address 1 sets it, and it raises irq when enabled. Reads at address 1 return the flags in bits [NCH-1:0].
- R10: Address 2 holds the channel enables in bits [NCH-1:0], the peripheral enable in bit 6 and the global enable in bit 7, and reads back the same layout. irq is 1 exactly when some flag is 1 with its channel enable set and both the peripheral and global enables are 1. Flags still set while any enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_in | input | NCH | Asynchronous comparator outputs |
| cyc_stb | input | 1 | First-phase strobe, once per instruction cycle |
| reg_en | input | 1 | Register access in this cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | 0 control, 1 flags, 2 enables |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid while reg_en is 1 and reg_wr is 0 |
| irq | output | 1 | Gated interrupt request |

## Verification
The bench tries to clear a flag while its mismatch is still active and expects the flag to stay at 1. A design that cleared it anyway would lose a change that software had not yet seen. Snapshot reload is checked separately for control reads and for control writes. A design that reloaded only on reads would leave the flag stuck after a write. The bench also lets the comparator fall back to the snapshot level with no register access. A design that latched the mismatch would refuse the following clear. With the strobe held low, the bench expects neither a flag nor a changed control read, which exposes a sample latch that runs every clock. It also steps through each of the three enables in turn, so an irq gate that ignores any one of them shows up.

// File: rtl/cci_pkg.sv
package cci_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int PE_BIT = 6;
  localparam int GE_BIT = 7;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 2'd0,
    A_FLAG = 2'd1,
    A_EN   = 2'd2
  } addr_e;
endpackage

// File: rtl/cci_sync.sv
module cci_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= din;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[k] <= '0;
      else        stg[k] <= stg[k-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/cci_detect.sv
module cci_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_stb,
  input  logic lvl,
  input  logic snap_ld,
  input  logic flag_we,
  input  logic flag_wd,
  output logic samp,
  output logic snap,
  output logic mism,
  output logic flag
);
  logic samp_q, samp_d;
  logic snap_q, snap_d;
  logic flag_q, flag_d;

  always_comb begin
    samp_d = samp_q;
    if (cyc_stb) samp_d = lvl;
    snap_d = snap_q;
    if (snap_ld) snap_d = samp_q;
    mism   = samp_q ^ snap_q;
    flag_d = flag_q;
    if (flag_we) flag_d = flag_wd;
    if (mism)    flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b0;
      snap_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      samp_q <= samp_d;
      snap_q <= snap_d;
      flag_q <= flag_d;
    end
  end

  assign samp = samp_q;
  assign snap = snap_q;
  assign flag = flag_q;
endmodule

// File: rtl/cci_regs.sv
module cci_regs
  import cci_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [NCH-1:0]    samp,
  input  logic [NCH-1:0]    flag,
  output logic              snap_ld,
  output logic              flag_we,
  output logic [NCH-1:0]    flag_wd,
  output logic [NCH-1:0]    chen,
  output logic              pe,
  output logic              ge,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic [NCH-1:0] chen_q, chen_d;
  logic           pe_q, pe_d, ge_q, ge_d;
  logic           en_we;
  logic           unused_wdata;
  addr_e          addr;

  assign addr         = addr_e'(reg_addr);
  assign unused_wdata = ^reg_wdata;

  always_comb begin
    snap_ld = reg_en && (addr == A_CTRL);
    flag_we = reg_en && reg_wr && (addr == A_FLAG);
    en_we   = reg_en && reg_wr && (addr == A_EN);
    flag_wd = reg_wdata[NCH-1:0];
    chen_d  = chen_q;
    pe_d    = pe_q;
    ge_d    = ge_q;
    if (en_we) begin
      chen_d = reg_wdata[NCH-1:0];
      pe_d   = reg_wdata[PE_BIT];
      ge_d   = reg_wdata[GE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chen_q <= '0;
      pe_q   <= 1'b0;
      ge_q   <= 1'b0;
    end else begin
      chen_q <= chen_d;
      pe_q   <= pe_d;
      ge_q   <= ge_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_en && !reg_wr) begin
      case (addr)
        A_CTRL: reg_rdata[NCH-1:0] = samp;
        A_FLAG: reg_rdata[NCH-1:0] = flag;
        A_EN: begin
          reg_rdata[NCH-1:0] = chen_q;
          reg_rdata[PE_BIT]  = pe_q;
          reg_rdata[GE_BIT]  = ge_q;
        end
        default: reg_rdata = '0;
      endcase
    end
  end

  assign chen = chen_q;
  assign pe   = pe_q;
  assign ge   = ge_q;
  assign irq  = (|(flag & chen_q)) && pe_q && ge_q;
endmodule

// File: rtl/cmp_chg_irq.sv
module cmp_chg_irq
  import cci_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    cmp_in,
  input  logic              cyc_stb,
  input  logic              reg_en,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic [NCH-1:0] lvl;
  logic [NCH-1:0] samp, snap, mism, flag;
  logic [NCH-1:0] flag_wd, chen;
  logic           snap_ld, flag_we, pe, ge;
  logic           unused_mism;

  assign unused_mism = ^mism;

  cci_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(cmp_in), .dout(lvl)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    cci_detect u_det (
      .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .lvl(lvl[i]),
      .snap_ld(snap_ld), .flag_we(flag_we), .flag_wd(flag_wd[i]),
      .samp(samp[i]), .snap(snap[i]), .mism(mism[i]), .flag(flag[i])
    );
  end

  cci_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .samp(samp), .flag(flag),
    .snap_ld(snap_ld), .flag_we(flag_we), .flag_wd(flag_wd), .chen(chen),
    .pe(pe), .ge(ge), .reg_rdata(reg_rdata), .irq(irq)
  );
endmodule

// File: rtl/cci_chk.sv
module cci_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cyc_stb,
  input logic           snap_ld,
  input logic           flag_we,
  input logic [NCH-1:0] flag_wd,
  input logic [NCH-1:0] samp,
  input logic [NCH-1:0] snap,
  input logic [NCH-1:0] flag,
  input logic [NCH-1:0] chen,
  input logic           pe,
  input logic           ge,
  input logic           irq
);
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_idle: assert (flag == '0 && samp == '0 && snap == '0 && !irq);
    end
  end

  a_r4_samp_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_stb |=> $stable(samp));

  a_r5_snap_reload: assert property (@(posedge clk) disable iff (!rst_n)
    snap_ld |=> (snap == $past(samp)));

  a_r10_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    !(pe && ge) |-> !irq);

  a_r10_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|(flag & chen)));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    a_r8_mismatch_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (samp[i] != snap[i]) |=> flag[i]);
    a_r9_soft_set: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we && flag_wd[i]) |=> flag[i]);
  end
endmodule

bind cmp_chg_irq cci_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .snap_ld(snap_ld),
  .flag_we(flag_we), .flag_wd(flag_wd), .samp(samp), .snap(snap),
  .flag(flag), .chen(chen), .pe(pe), .ge(ge), .irq(irq)
);

// File: tb/tb_cmp_chg_irq.sv
`timescale 1ns/1ps
module tb_cmp_chg_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cmp_in = 2'b00;
  logic       cyc_stb = 1'b1;
  logic       reg_en = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  cmp_chg_irq dut (
    .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .cyc_stb(cyc_stb),
    .reg_en(reg_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // monitor: pops the expected item for every read cycle
  always @(negedge clk) begin
    if (rst_n && reg_en && !reg_wr) begin
      if (sb.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL unexpected read: actual %h expected none", reg_rdata);
      end else begin
        item_t it;
        it = sb.pop_front();
        n_tests++;
        if (reg_rdata !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", it.tag, reg_rdata, it.exp);
        end
      end
    end
  end

  task automatic bus_read(input logic [1:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sb.push_back(it);
    @(posedge clk); #1;
    reg_en = 1'b1; reg_wr = 1'b0; reg_addr = a;
    @(posedge clk); #1;
    reg_en = 1'b0;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    reg_en = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_en = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    n_tests++;
    if (irq !== e) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, irq, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    chk_irq(1'b0, "R1 irq in reset");
    rst_n = 1'b1;
    idle(2);
    bus_read(2'd0, 8'h00, "R1 R2 ctrl after reset");
    bus_read(2'd1, 8'h00, "R1 flags after reset");
    chk_irq(1'b0, "R1 irq after reset");

    // enables: ch0, ch1, peripheral, global
    bus_write(2'd2, 8'hC3);
    bus_read(2'd2, 8'hC3, "R10 enable readback");

    // R3: ch0 rises
    cmp_in = 2'b01; idle(6);
    chk_irq(1'b1, "R3 R10 irq from ch0");
    bus_read(2'd1, 8'h01, "R3 only ch0 flag");
    bus_read(2'd0, 8'h01, "R2 ctrl shows level");
    bus_write(2'd1, 8'h00);
    bus_read(2'd1, 8'h00, "R5 clear after ctrl read");
    chk_irq(1'b0, "R5 irq dropped");

    // R8: clear refused while mismatch lasts, then R6 write ends it
    cmp_in = 2'b11; idle(6);
    bus_write(2'd1, 8'h00);
    bus_read(2'd1, 8'h02, "R8 clear ignored during mismatch");
    bus_write(2'd0, 8'h00);
    bus_write(2'd1, 8'h00);
    bus_read(2'd1, 8'h00, "R6 clear after ctrl write");

    // R7: comparator returns to snapshot level
    cmp_in = 2'b01; idle(6);
    bus_read(2'd1, 8'h02, "R7 ch1 fall flagged");
    cmp_in = 2'b11; idle(6);
    bus_write(2'd1, 8'h00);
    bus_read(2'd1, 8'h00, "R7 clear after level returned");

    // R9: software-set
    bus_write(2'd1, 8'h01);
    bus_read(2'd1, 8'h01, "R9 soft set");
    chk_irq(1'b1, "R9 soft irq");
    bus_write(2'd1, 8'h00);
    chk_irq(1'b0, "R9 soft clear");

    // R10: enable gating
    bus_write(2'd2, 8'h83);
    cmp_in = 2'b10; idle(6);
    chk_irq(1'b0, "R10 peripheral enable off");
    bus_read(2'd1, 8'h01, "R10 flag sets while gated");
    bus_write(2'd2, 8'h43);
    chk_irq(1'b0, "R10 global enable off");
    bus_write(2'd2, 8'hC3);
    chk_irq(1'b1, "R10 all enables on");
    bus_write(2'd2, 8'hC2);
    chk_irq(1'b0, "R10 channel enable off");
    bus_read(2'd0, 8'h02, "R2 ctrl after ch0 fall");
    bus_write(2'd1, 8'h00);

    // R4: strobe held low
    cyc_stb = 1'b0;
    cmp_in = 2'b00; idle(8);
    bus_read(2'd1, 8'h00, "R4 no flag without strobe");
    bus_read(2'd0, 8'h02, "R4 sample latch held");
    cyc_stb = 1'b1; idle(6);
    bus_read(2'd1, 8'h02, "R4 flag once strobe resumes");

    idle(3);
    if (sb.size() != 0) begin
      n_tests++; n_fail++;
      $display("FAIL scoreboard: actual %0d left expected 0", sb.size());
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule